// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a single serial bit and flags, one cycle later, every point where the four most recent samples spell either of two target patterns: four ones in a row, or one-one-zero-one. It is a Moore machine, so the flag depends only on the registered state. Matches may overlap, so a long run of ones or a repeating tail keeps raising the flag without a gap.

The current three-bit state code is driven out beside the flag. This lets a monitor see how far the machine has progressed into a candidate pattern. Reset is synchronous and active low, and the idle code is all zeros.

Top module: `seq_pair_detector`

## Requirements
- R1: `z_out` is 1 in the cycle after a clock edge exactly when the last four `w_in` samples, oldest first, were 1,1,1,1 or 1,1,0,1; otherwise it is 0.
- R2: Matches overlap: five consecutive ones raise `z_out` after the fourth and after the fifth sample.
- R3: After a 1,1,0,1 match, the final 1 opens a new candidate: the stream 1,1,0,1,1,0,1 raises `z_out` after the fourth and the seventh sample.
- R4: `state_out` encodes the progress: 3'b000 no useful suffix, 3'b001 last sample 1, 3'b010 last two 1,1, 3'b011 last three 1,1,0, 3'b100 last three 1,1,1, 3'b101 last four 1,1,0,1, 3'b110 last four 1,1,1,1.
- R5: While `rst_n` is 0, each rising clock edge forces `state_out` to 3'b000 and `z_out` to 0, whatever `w_in` is; the state does not change before that edge.
- R6: `z_out` stays 0 until at least four samples have been taken since reset was released.
- R7: `state_out` never shows 3'b111; an unused code goes to 3'b000 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `w_in` is sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| w_in | input | 1 | Serial input bit |
| z_out | output | 1 | Pattern-match flag |
| state_out | output | 3 | Current state code |

## Verification
A wrong transition shows up on `state_out` at the very next sample, because every code names a unique suffix of the input history. A wrong transition that lands in a non-matching state shows up on `z_out` within at most four samples, as a missed or spurious match. A reset that acts asynchronously is caught when the state changes before the edge. A lost overlap path, from a match state back into a partial state, is caught by the overlapping runs and by the repeated 1,1,0,1 stream.

// File: rtl/seq_pair_pkg.sv
package seq_pair_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_ONE    = 3'b001,
    ST_TWO    = 3'b010,
    ST_GAP    = 3'b011,
    ST_THREE  = 3'b100,
    ST_HITGAP = 3'b101,
    ST_HITRUN = 3'b110
  } det_state_e;
endpackage

// File: rtl/seq_pair_next.sv
module seq_pair_next
  import seq_pair_pkg::*;
(
  input  logic [ST_W-1:0] cur_st,
  input  logic            w,
  output logic [ST_W-1:0] nxt_st
);
  always_comb begin
    case (cur_st)
      ST_IDLE:   nxt_st = w ? ST_ONE   : ST_IDLE;
      ST_ONE:    nxt_st = w ? ST_TWO   : ST_IDLE;
      ST_TWO:    nxt_st = w ? ST_THREE : ST_GAP;
      ST_GAP:    nxt_st = w ? ST_HITGAP : ST_IDLE;
      ST_THREE:  nxt_st = w ? ST_HITRUN : ST_GAP;
      ST_HITGAP: nxt_st = w ? ST_TWO   : ST_IDLE;
      ST_HITRUN: nxt_st = w ? ST_HITRUN : ST_GAP;
      default:   nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/seq_pair_out.sv
module seq_pair_out
  import seq_pair_pkg::*;
(
  input  logic [ST_W-1:0] cur_st,
  output logic            hit
);
  always_comb begin
    hit = (cur_st == ST_HITGAP) || (cur_st == ST_HITRUN);
  end
endmodule

// File: rtl/seq_pair_detector.sv
module seq_pair_detector
  import seq_pair_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_in,
  output logic            z_out,
  output logic [ST_W-1:0] state_out
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;

  seq_pair_next u_next (
    .cur_st (st_q),
    .w      (w_in),
    .nxt_st (st_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  seq_pair_out u_out (
    .cur_st (st_q),
    .hit    (z_out)
  );

  assign state_out = st_q;
endmodule

// File: rtl/seq_pair_detector_chk.sv
module seq_pair_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       w_in,
  input logic       z_out,
  input logic [2:0] state_out
);
  logic [3:0] hist_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= 4'b0000;
      cnt_q  <= 3'd0;
    end else begin
      hist_q <= {hist_q[2:0], w_in};
      if (cnt_q != 3'd4) cnt_q <= cnt_q + 3'd1;
    end
  end

  // R1
  match_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 3'd4) |-> (z_out == ((hist_q == 4'b1111) || (hist_q == 4'b1101))));

  // R6
  early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 3'd4) |-> !z_out);

  // R5
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (state_out == 3'b000 && !z_out));

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_out != 3'b111);

  // R7
  unused_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out == 3'b111) |=> (state_out == 3'b000));

  // R3
  tail_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out == 3'b101 && w_in) |=> (state_out == 3'b010));
endmodule

bind seq_pair_detector seq_pair_detector_chk u_chk (.*);

// File: tb/seq_pair_detector_tb.sv
module seq_pair_detector_tb;
  logic       clk;
  logic       rst_n;
  logic       w_in;
  logic       z_out;
  logic [2:0] state_out;

  int unsigned total;
  int unsigned bad;
  logic [3:0]  hist;
  int unsigned nsamp;
  bit          done;

  seq_pair_detector u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .w_in      (w_in),
    .z_out     (z_out),
    .state_out (state_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic exp_z(input logic [3:0] h, input int unsigned n);
    return (n >= 4) && ((h == 4'b1111) || (h == 4'b1101));
  endfunction

  function automatic logic [2:0] exp_state(input logic [3:0] h, input int unsigned n);
    if (n >= 4 && h == 4'b1111) return 3'b110;
    if (n >= 4 && h == 4'b1101) return 3'b101;
    if (n >= 3 && h[2:0] == 3'b111) return 3'b100;
    if (n >= 3 && h[2:0] == 3'b110) return 3'b011;
    if (n >= 2 && h[1:0] == 2'b11) return 3'b010;
    if (n >= 1 && h[0]) return 3'b001;
    return 3'b000;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input string ztag);
    w_in = b;
    @(posedge clk);
    hist = {hist[2:0], b};
    if (nsamp < 100) nsamp++;
    @(negedge clk);
    check(ztag, {7'd0, z_out}, {7'd0, exp_z(hist, nsamp)});
    check("R4", {5'd0, state_out}, {5'd0, exp_state(hist, nsamp)});
    check("R7", {7'd0, (state_out == 3'b111)}, 8'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    w_in  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5", {5'd0, state_out}, 8'd0);
    check("R5", {7'd0, z_out}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    check("R5", {5'd0, state_out}, 8'd0);
    rst_n = 1'b1;
    hist  = 4'b0000;
    nsamp = 0;
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    hist = 4'b0000; nsamp = 0;
    rst_n = 1'b0; w_in = 1'b0;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R6: three ones, no flag yet
    step(1'b1, "R6"); step(1'b1, "R6"); step(1'b1, "R6");
    // R2: fourth and fifth ones both flag
    step(1'b1, "R2"); step(1'b1, "R2");
    check("R2", {7'd0, z_out}, 8'd1);
    step(1'b0, "R1");

    // R3: 1101101
    do_reset();
    step(1'b1, "R3"); step(1'b1, "R3"); step(1'b0, "R3"); step(1'b1, "R3");
    check("R3", {7'd0, z_out}, 8'd1);
    step(1'b1, "R3"); step(1'b0, "R3"); step(1'b1, "R3");
    check("R3", {7'd0, z_out}, 8'd1);

    // R1: 1,1,1,0,1 ends in 1101
    step(1'b0, "R1"); step(1'b0, "R1");
    step(1'b1, "R1"); step(1'b1, "R1"); step(1'b1, "R1"); step(1'b0, "R1"); step(1'b1, "R1");
    check("R1", {7'd0, z_out}, 8'd1);

    // R5: reset is synchronous, no change before the edge
    step(1'b1, "R1"); step(1'b1, "R1");
    rst_n = 1'b0;
    #1;
    check("R5", {5'd0, state_out}, {5'd0, exp_state(hist, nsamp)});
    do_reset();

    // random section, biased toward ones
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, "R1");
      if (($urandom % 500) == 0) do_reset();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule